// File: doc/BRIEF.md
# Block transfer micro-op sequencer

This block turns one multi-register load or store instruction into a stream of micro-operation records, one record per handshake on its output. The instruction arrives as a register-select mask, a base register number and five control bits: direction (up/down), pre/post indexing, base update, load/store, and a privileged flag. The sequencer first emits a record that copies the base into a hidden scratch register. It then emits one transfer record per selected register, each addressed as an offset from that scratch register. A final base-update record follows when base update was requested.

The records are consumed by an execution pipeline that performs the memory accesses, register writes and mode changes. The sequencer only describes them. The privileged flag selects between two behaviours. Without the top register (the program counter) in the mask, every transfer targets the user-bank copy of its register. With the program counter in the mask and a load requested, the load of the program counter becomes a load that also restores the status word from its saved copy.

Top module: `blkxfer_seq`

## Requirements
- R1: A new instruction is taken only when `in_ready` is high, which happens only when no sequence is in progress. The first record after acceptance has kind COPY (0), target register 2*NREG (the scratch register, 32 by default), source register equal to the base, and immediate 0.
- R2: With N selected registers, the first transfer offset is 0 when up=1 and 4*N-4 when up=0. Pre-indexing adds 4 to this value.
- R3: Transfer records appear in ascending register order, exactly one per selected bit. Their source register is the scratch register.
- R4: Each transfer offset is the previous one plus 4 (up=1) or minus 4 (up=0). `uop_sub` equals the inverse of up on every transfer.
- R5: With base update set, the final record has kind ADDI (4) when up=1 or SUBI (5) when up=0. Its target and source are the base, its immediate is 4*N, and it carries `uop_last`.
- R6: With base update clear, the last transfer record carries `uop_last`, and no earlier record does.
- R7: With the privileged flag set and bit 15 of the mask clear, each transfer target is the register number plus NREG (the user bank).
- R8: With the privileged flag set, a load, and bit 15 of the mask set, the transfer of register 15 has kind LOAD_RET (2). The other loads have kind LOAD (1) and unmapped targets. Without the privileged flag, loads are kind LOAD, and stores are kind STORE (3) in every case.
- R9: An empty mask yields a single COPY record with both `uop_last` and `uop_err` set.
- R10: While `uop_valid` is high and `uop_ready` is low, all record fields hold their values.
- R11: A sequence has exactly 1+N records, plus one when base update is set. `uop_valid` is low in the cycle after the last record is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction will be taken |
| in_list | input | NREG | Register-select mask |
| in_base | input | log2(NREG) | Base register number |
| in_up | input | 1 | 1 = addresses ascend |
| in_pre | input | 1 | 1 = pre-indexed |
| in_wb | input | 1 | 1 = update base at the end |
| in_load | input | 1 | 1 = load, 0 = store |
| in_priv | input | 1 | Privileged flag (user bank or status restore) |
| uop_valid | output | 1 | Record present |
| uop_ready | input | 1 | Consumer takes the record |
| uop_kind | output | 3 | 0 COPY, 1 LOAD, 2 LOAD_RET, 3 STORE, 4 ADDI, 5 SUBI |
| uop_reg | output | log2(NREG)+2 | Target register |
| uop_base | output | log2(NREG)+2 | Source register |
| uop_imm | output | log2(NREG*4)+1 | Immediate or offset |
| uop_sub | output | 1 | Offset is subtracted |
| uop_last | output | 1 | Final record of the sequence |
| uop_err | output | 1 | Empty mask |

## Verification
The same scattered five-register mask is run under all four direction/indexing combinations, which separates the four starting offsets and the two step directions. Masks with and without the program counter, under privileged and ordinary loads and stores, separate user-bank remapping from status-restoring loads. A full sixteen-register mask with base update is run under a stalling consumer while a second instruction is held on the input; this exposes lost state, dropped records and premature acceptance. Empty and single-register masks probe the ends of the offset range and the error marking.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
   typedef enum logic [2:0] {
      UOP_COPY     = 3'd0,
      UOP_LOAD     = 3'd1,
      UOP_LOAD_RET = 3'd2,
      UOP_STORE    = 3'd3,
      UOP_ADDI     = 3'd4,
      UOP_SUBI     = 3'd5
   } uop_kind_e;

   typedef enum logic [1:0] {
      PH_COPY = 2'd0,
      PH_XFER = 2'd1,
      PH_WB   = 2'd2
   } seq_phase_e;
endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
   parameter int W  = 16,
   parameter int CW = $clog2(W) + 1
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < W; i++) begin
         cnt = cnt + CW'(vec[i]);
      end
   end
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
   parameter int W  = 16,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [W-1:0]  onehot,
   output logic [IW-1:0] idx,
   output logic          single
);
   assign onehot = vec & (~vec + 1'b1);
   assign single = (vec != '0) && ((vec & (vec - 1'b1)) == '0);

   for (genvar b = 0; b < IW; b++) begin : g_enc
      logic [W-1:0] sel;
      for (genvar i = 0; i < W; i++) begin : g_sel
         if (((i >> b) & 1) == 1) begin : g_on
            assign sel[i] = onehot[i];
         end else begin : g_off
            assign sel[i] = 1'b0;
         end
      end
      assign idx[b] = |sel;
   end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                in_valid,
   output logic                                in_ready,
   input  logic [NREG-1:0]                     in_list,
   input  logic [$clog2(NREG)-1:0]             in_base,
   input  logic                                in_up,
   input  logic                                in_pre,
   input  logic                                in_wb,
   input  logic                                in_load,
   input  logic                                in_priv,
   output logic                                uop_valid,
   input  logic                                uop_ready,
   output logic [2:0]                          uop_kind,
   output logic [$clog2(NREG)+1:0]             uop_reg,
   output logic [$clog2(NREG)+1:0]             uop_base,
   output logic [$clog2(NREG*WORD_BYTES):0]    uop_imm,
   output logic                                uop_sub,
   output logic                                uop_last,
   output logic                                uop_err
);
   localparam int IDX_W = $clog2(NREG);
   localparam int CNT_W = IDX_W + 1;
   localparam int REG_W = IDX_W + 2;
   localparam int OFF_W = $clog2(NREG * WORD_BYTES) + 1;
   localparam logic [REG_W-1:0] TMP_REG  = REG_W'(2 * NREG);
   localparam logic [REG_W-1:0] USER_OFS = REG_W'(NREG);
   localparam logic [IDX_W-1:0] PC_IDX   = IDX_W'(NREG - 1);
   localparam logic [OFF_W-1:0] STEP     = OFF_W'(WORD_BYTES);

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("WORD_BYTES must be a power of two");
   end

   logic              busy;
   seq_phase_e        phase;
   logic [NREG-1:0]   rem;
   logic [OFF_W-1:0]  off;
   logic [CNT_W-1:0]  r_cnt;
   logic [IDX_W-1:0]  r_base;
   logic              r_up, r_wb, r_load, r_user, r_ret;

   logic [CNT_W-1:0]  cnt_in;
   logic [OFF_W-1:0]  span_in, start_off, span_r;
   logic [NREG-1:0]   pick_oh;
   logic [IDX_W-1:0]  pick_idx;
   logic              pick_single;
   logic              take, fire;

   blkxfer_popcnt #(.W(NREG), .CW(CNT_W)) u_cnt (
      .vec (in_list),
      .cnt (cnt_in)
   );

   blkxfer_lowbit #(.W(NREG), .IW(IDX_W)) u_pick (
      .vec    (rem),
      .onehot (pick_oh),
      .idx    (pick_idx),
      .single (pick_single)
   );

   assign span_in   = OFF_W'(cnt_in) * STEP;
   assign span_r    = OFF_W'(r_cnt) * STEP;
   assign start_off = (in_up ? '0 : (span_in - STEP)) + (in_pre ? STEP : '0);

   assign in_ready  = !busy;
   assign take      = in_valid && !busy;
   assign uop_valid = busy;
   assign fire      = busy && uop_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         phase  <= PH_COPY;
         rem    <= '0;
         off    <= '0;
         r_cnt  <= '0;
         r_base <= '0;
         r_up   <= 1'b0;
         r_wb   <= 1'b0;
         r_load <= 1'b0;
         r_user <= 1'b0;
         r_ret  <= 1'b0;
      end else if (take) begin
         busy   <= 1'b1;
         phase  <= PH_COPY;
         rem    <= in_list;
         off    <= start_off;
         r_cnt  <= cnt_in;
         r_base <= in_base;
         r_up   <= in_up;
         r_wb   <= in_wb;
         r_load <= in_load;
         r_user <= in_priv && !in_list[NREG-1];
         r_ret  <= in_priv && in_load && in_list[NREG-1];
      end else if (fire) begin
         unique case (phase)
            PH_COPY: begin
               if (r_cnt == '0) busy  <= 1'b0;
               else             phase <= PH_XFER;
            end
            PH_XFER: begin
               rem <= rem & ~pick_oh;
               off <= r_up ? (off + STEP) : (off - STEP);
               if (pick_single) begin
                  if (r_wb) phase <= PH_WB;
                  else      busy  <= 1'b0;
               end
            end
            default: busy <= 1'b0;
         endcase
      end
   end

   always_comb begin
      uop_kind = UOP_COPY;
      uop_reg  = TMP_REG;
      uop_base = REG_W'(r_base);
      uop_imm  = '0;
      uop_sub  = 1'b0;
      uop_last = 1'b0;
      uop_err  = 1'b0;
      unique case (phase)
         PH_COPY: begin
            uop_last = (r_cnt == '0);
            uop_err  = (r_cnt == '0);
         end
         PH_XFER: begin
            if (!r_load)                         uop_kind = UOP_STORE;
            else if (r_ret && pick_idx == PC_IDX) uop_kind = UOP_LOAD_RET;
            else                                 uop_kind = UOP_LOAD;
            uop_reg  = r_user ? (REG_W'(pick_idx) + USER_OFS) : REG_W'(pick_idx);
            uop_base = TMP_REG;
            uop_imm  = off;
            uop_sub  = !r_up;
            uop_last = pick_single && !r_wb;
         end
         default: begin
            uop_kind = r_up ? UOP_ADDI : UOP_SUBI;
            uop_reg  = REG_W'(r_base);
            uop_imm  = span_r;
            uop_sub  = !r_up;
            uop_last = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              in_valid,
   input logic                              in_ready,
   input logic                              uop_valid,
   input logic                              uop_ready,
   input logic [2:0]                        uop_kind,
   input logic [$clog2(NREG)+1:0]           uop_reg,
   input logic [$clog2(NREG)+1:0]           uop_base,
   input logic [$clog2(NREG*WORD_BYTES):0]  uop_imm,
   input logic                              uop_last,
   input logic                              uop_err
);
   localparam int REG_W = $clog2(NREG) + 2;
   localparam logic [REG_W-1:0] TMP_REG = REG_W'(2 * NREG);

   // R1
   copy_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> uop_valid && uop_kind == 3'd0 &&
                               uop_reg == TMP_REG && uop_imm == '0);

   // R3
   xfer_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uop_valid && (uop_kind == 3'd1 || uop_kind == 3'd2 || uop_kind == 3'd3)
      |-> uop_base == TMP_REG);

   // R5
   wb_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uop_valid && (uop_kind == 3'd4 || uop_kind == 3'd5) |-> uop_last);

   // R9
   empty_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uop_valid && uop_err |-> uop_last && uop_kind == 3'd0);

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uop_valid && !uop_ready |=> uop_valid && $stable(uop_kind) &&
         $stable(uop_reg) && $stable(uop_base) && $stable(uop_imm) &&
         $stable(uop_last));

   // R11
   seq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uop_valid && uop_ready && uop_last |=> !uop_valid);
endmodule

bind blkxfer_seq blkxfer_seq_chk #(.NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .uop_valid (uop_valid),
   .uop_ready (uop_ready),
   .uop_kind  (uop_kind),
   .uop_reg   (uop_reg),
   .uop_base  (uop_base),
   .uop_imm   (uop_imm),
   .uop_last  (uop_last),
   .uop_err   (uop_err)
);

// File: tb/blkxfer_seq_test.sv
module blkxfer_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_list = '0;
   logic [3:0]  in_base = '0;
   logic        in_up = 1'b0, in_pre = 1'b0, in_wb = 1'b0, in_load = 1'b0, in_priv = 1'b0;
   logic        uop_valid;
   logic        uop_ready = 1'b0;
   logic [2:0]  uop_kind;
   logic [5:0]  uop_reg, uop_base;
   logic [6:0]  uop_imm;
   logic        uop_sub, uop_last, uop_err;

   int checks = 0;
   int errors = 0;

   int e_kind [20];
   int e_reg  [20];
   int e_base [20];
   int e_imm  [20];
   int e_sub  [20];
   int e_last [20];
   int e_err  [20];
   int e_total;

   always #5 clk = ~clk;

   blkxfer_seq uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_list(in_list), .in_base(in_base), .in_up(in_up), .in_pre(in_pre),
      .in_wb(in_wb), .in_load(in_load), .in_priv(in_priv),
      .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_kind(uop_kind),
      .uop_reg(uop_reg), .uop_base(uop_base), .uop_imm(uop_imm),
      .uop_sub(uop_sub), .uop_last(uop_last), .uop_err(uop_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Reference model of the record stream.
   task automatic model(input logic [15:0] lst, input int base, input bit up,
                        input bit pre, input bit wb, input bit ld, input bit pv);
      int n = 0, off, k, left;
      for (int i = 0; i < 16; i++) if (lst[i]) n++;
      off = up ? 0 : 4 * n - 4;
      if (pre) off += 4;
      e_kind[0] = 0; e_reg[0] = 32; e_base[0] = base; e_imm[0] = 0;
      e_sub[0] = 0; e_last[0] = (n == 0); e_err[0] = (n == 0);
      k = 1; left = n;
      for (int i = 0; i < 16; i++) begin
         if (lst[i]) begin
            left--;
            if (!ld) e_kind[k] = 3;
            else if (pv && lst[15] && i == 15) e_kind[k] = 2;
            else e_kind[k] = 1;
            e_reg[k]  = (pv && !lst[15]) ? i + 16 : i;
            e_base[k] = 32;
            e_imm[k]  = off;
            e_sub[k]  = !up;
            e_last[k] = (left == 0) && !wb;
            e_err[k]  = 0;
            off = up ? off + 4 : off - 4;
            k++;
         end
      end
      if (wb && n != 0) begin
         e_kind[k] = up ? 4 : 5; e_reg[k] = base; e_base[k] = base;
         e_imm[k] = 4 * n; e_sub[k] = !up; e_last[k] = 1; e_err[k] = 0;
         k++;
      end
      e_total = k;
   endtask

   task automatic run(input string req, input logic [15:0] lst, input int base,
                      input bit up, input bit pre, input bit wb, input bit ld,
                      input bit pv, input bit stall, input bit poke);
      int k = 0, cyc = 0;
      bit done = 0;
      bit ok;
      model(lst, base, up, pre, wb, ld, pv);
      @(negedge clk);
      in_list = lst; in_base = 4'(base); in_up = up; in_pre = pre;
      in_wb = wb; in_load = ld; in_priv = pv; in_valid = 1'b1;
      chk(in_ready == 1'b1, "R1", "idle ready before offer", in_ready, 1);
      @(negedge clk);
      if (poke) in_list = ~lst;
      else      in_valid = 1'b0;
      while (!done && cyc < 100) begin
         uop_ready = stall ? ((cyc % 3) != 1) : 1'b1;
         if (poke) chk(in_ready == 1'b0, "R1", "ready while busy", in_ready, 0);
         if (k >= 20) begin
            chk(0, "R11", "too many records", k, e_total);
            done = 1;
         end else begin
            ok = uop_valid && uop_kind == 3'(e_kind[k]) && uop_reg == 6'(e_reg[k]) &&
                 uop_base == 6'(e_base[k]) && uop_imm == 7'(e_imm[k]) &&
                 uop_sub == 1'(e_sub[k]) && uop_last == 1'(e_last[k]) &&
                 uop_err == 1'(e_err[k]);
            chk(ok, req, $sformatf("record %0d {v,kind,reg,base,imm,sub,last,err}", k),
                {uop_valid, uop_kind, uop_reg, uop_base, uop_imm, uop_sub, uop_last, uop_err},
                {1'b1, 3'(e_kind[k]), 6'(e_reg[k]), 6'(e_base[k]), 7'(e_imm[k]),
                 1'(e_sub[k]), 1'(e_last[k]), 1'(e_err[k])});
            if (uop_ready && uop_valid) begin
               if (uop_last) begin done = 1; in_valid = 1'b0; end
               k++;
            end
         end
         @(negedge clk);
         cyc++;
      end
      uop_ready = 1'b0;
      chk(k == e_total, "R11", "record count", k, e_total);
      chk(!uop_valid && in_ready, "R11", "idle after last", {uop_valid, in_ready}, 2'b01);
   endtask

   task automatic t_reset;
      chk(!uop_valid && in_ready, "R1", "reset state", {uop_valid, in_ready}, 2'b01);
   endtask

   task automatic t_modes;
      // R2 R3 R4 R6: four direction/index combinations
      run("R2 R3 R4 R6 (IA)", 16'h0a31, 5, 1, 0, 0, 1, 0, 0, 0);
      run("R2 R3 R4 R6 (IB)", 16'h0a31, 5, 1, 1, 0, 1, 0, 0, 0);
      run("R2 R3 R4 R6 (DA)", 16'h0a31, 5, 0, 0, 0, 1, 0, 0, 0);
      run("R2 R3 R4 R6 (DB)", 16'h0a31, 5, 0, 1, 0, 1, 0, 0, 0);
      run("R2 single", 16'h0001, 2, 0, 1, 0, 0, 0, 0, 0);
   endtask

   task automatic t_wb;
      run("R5 up", 16'h8002, 3, 1, 0, 1, 0, 0, 0, 0);
      run("R5 down", 16'h8002, 3, 0, 1, 1, 0, 0, 0, 0);
   endtask

   task automatic t_user;
      run("R7 user bank", 16'h00f0, 13, 1, 0, 0, 1, 1, 0, 0);
      run("R7 store user", 16'h0421, 1, 0, 0, 1, 0, 1, 0, 0);
      run("R8 store pc priv", 16'h8001, 1, 1, 0, 0, 0, 1, 0, 0);
   endtask

   task automatic t_excret;
      run("R8 ret load", 16'h8003, 13, 1, 0, 1, 1, 1, 0, 0);
      run("R8 plain pc load", 16'h8003, 13, 1, 0, 0, 1, 0, 0, 0);
   endtask

   task automatic t_empty;
      run("R9 empty", 16'h0000, 7, 1, 0, 1, 1, 0, 0, 0);
   endtask

   task automatic t_stall;
      run("R10 R1 stall full", 16'hffff, 0, 1, 1, 1, 1, 0, 1, 1);
      run("R10 stall down", 16'h1248, 9, 0, 0, 1, 0, 1, 1, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      chk(0, "ALL", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_modes;
      t_wb;
      t_user;
      t_excret;
      t_empty;
      t_stall;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule